// File: doc/BRIEF.md
# Edge and pulse-width interval timer

This block times intervals on one of several digital inputs, counting pulses of an external tick strobe (1.6 us per count in the intended system). One counter serves both modes. In edge mode the count starts at the start strobe and stops when the selected input moves from the non-target level to the target level. In width mode the block first waits for the input to enter the target level, and then counts until the input leaves it. The target level is chosen per measurement, so either polarity of pulse or edge can be timed.

The host selects a pin, a mode and a target level and pulses `start_i`. The result, the done flag and the overflow flag then hold their values until the next start. The inputs are expected to be synchronized already, and the tick strobe comes from outside the block.

Top module: `evt_interval_timer`

## Requirements
- R1: After reset `result_o` is 0 and `done_o`, `ovf_o` and `busy_o` are 0.
- R2: In edge mode (`mode_width_i`=0) the result equals the number of clock edges with `tick_i`=1 between the start edge and the edge at which the selected input first moves from non-target to target. A tick on that final edge is not counted. `done_o` rises one cycle after that transition is sampled.
- R3: In width mode (`mode_width_i`=1), ticks that arrive before the input enters the target level are not counted. The count runs from that entry until the input leaves the target level, using the same edge rules as R2.
- R4: `target_lvl_i`=1 makes logic 1 the target level and `target_lvl_i`=0 makes logic 0 the target level. Both modes honour this choice.
- R5: Only `pin_sel_i` values 1 to NUM_PINS-1 start a measurement. A start with value 0 (or any larger value) leaves `busy_o`=0 and `done_o`=0, clears `result_o` to 0, and ignores the mode and target inputs.
- R6: The count advances only on tick pulses. Transitions on pins other than the selected one have no effect.
- R7: When a tick arrives while the count already equals 0xFFFF, the count holds at 0xFFFF and the measurement ends with `ovf_o`=1 and `done_o`=1.
- R8: Once `done_o` is set, `result_o`, `done_o` and `ovf_o` stay unchanged until the next start strobe, whatever the pins and ticks do.
- R9: A start strobe during a measurement restarts it. The count clears to 0 and `done_o`/`ovf_o` clear on the next cycle.
- R10: In edge mode, an input that is already at the target level when the start arrives does not end the measurement. A fresh non-target-to-target transition is required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start/restart strobe, one cycle |
| pin_sel_i | input | 3 | Pin index to time (1..4 valid) |
| mode_width_i | input | 1 | 0 = edge mode, 1 = width mode |
| target_lvl_i | input | 1 | Target logic level |
| tick_i | input | 1 | Count-enable strobe (one resolution step) |
| pins_i | input | 5 | Synchronized digital inputs |
| result_o | output | 16 | Measured count |
| done_o | output | 1 | Measurement finished |
| ovf_o | output | 1 | Measurement ended by saturation |
| busy_o | output | 1 | Waiting for arm or counting |

## Verification
Some rules are checked by the assertions on every cycle. The counter never wraps past all-ones and stays frozen without a tick. A finished result stays frozen until a start. Overflow never appears without done. Every start clears the result on the next cycle, and a start with an invalid pin leaves the block idle. Other behaviours can only be shown by the bench's scenarios: the exact tick counts of both modes across every pin and both polarities, the exclusion of a tick that coincides with the ending transition, immunity to activity on unselected pins, the need for a fresh transition in edge mode, and the full-range overflow.

// File: rtl/ltim_pkg.sv
package ltim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } ltim_state_e;
endpackage

// File: rtl/ltim_pin_watch.sv
module ltim_pin_watch #(
  parameter int NUM_PINS = 5,
  localparam int SEL_W = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                target_i,
  output logic                enter_o,
  output logic                leave_o
);
  logic [NUM_PINS-1:0] pins_q;
  logic [NUM_PINS-1:0] enter_v, leave_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= '0;
    else         pins_q <= pins_i;
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign enter_v[g] = (pins_i[g] == target_i) && (pins_q[g] != target_i);
    assign leave_v[g] = (pins_i[g] != target_i) && (pins_q[g] == target_i);
  end

  always_comb begin
    enter_o = 1'b0;
    leave_o = 1'b0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (sel_i == SEL_W'(i)) begin
        enter_o = enter_v[i];
        leave_o = leave_v[i];
      end
    end
  end
endmodule

// File: rtl/ltim_counter.sv
module ltim_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CNT_MAX);

  // R7
  cnt_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R6
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_interval_timer.sv
module evt_interval_timer
  import ltim_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int CNT_W    = 16,
  localparam int SEL_W   = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SEL_W-1:0]    pin_sel_i,
  input  logic                mode_width_i,
  input  logic                target_lvl_i,
  input  logic                tick_i,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [CNT_W-1:0]    result_o,
  output logic                done_o,
  output logic                ovf_o,
  output logic                busy_o
);
  ltim_state_e      state_q;
  logic [SEL_W-1:0] sel_q;
  logic             mode_q, tgt_q, done_q, ovf_q;
  logic             enter, leave, end_evt, at_max, inc, pin_ok;

  // pin 0 cannot time
  assign pin_ok  = (pin_sel_i != '0) && (int'(pin_sel_i) < NUM_PINS);
  assign end_evt = mode_q ? leave : enter;
  assign inc     = !start_i && (state_q == ST_COUNT) && tick_i && !end_evt;

  ltim_pin_watch #(.NUM_PINS(NUM_PINS)) u_watch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pins_i   (pins_i),
    .sel_i    (sel_q),
    .target_i (tgt_q),
    .enter_o  (enter),
    .leave_o  (leave)
  );

  ltim_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .inc_i    (inc),
    .cnt_o    (result_o),
    .at_max_o (at_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      mode_q  <= 1'b0;
      tgt_q   <= 1'b0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (start_i) begin
      sel_q   <= pin_ok ? pin_sel_i : '0;
      mode_q  <= pin_ok & mode_width_i;
      tgt_q   <= pin_ok & target_lvl_i;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      state_q <= !pin_ok ? ST_IDLE : (mode_width_i ? ST_ARM : ST_COUNT);
    end else begin
      unique case (state_q)
        ST_ARM:   if (enter) state_q <= ST_COUNT;
        ST_COUNT: begin
          if (end_evt) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else if (tick_i && at_max) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
            ovf_q   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign done_o = done_q;
  assign ovf_o  = ovf_q;
  assign busy_o = (state_q == ST_ARM) || (state_q == ST_COUNT);

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(result_o) && $stable(ovf_o)));

  // R5
  bad_pin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !pin_ok) |=> (!busy_o && !done_o));

  // R9
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (result_o == '0 && !done_o && !ovf_o));

  // R7
  ovf_implies_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> done_o);
endmodule

// File: tb/evt_interval_timer_tb.sv
module evt_interval_timer_tb;
  localparam int NP = 5;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    sel = '0;
  logic          mode = 1'b0;
  logic          tgt = 1'b0;
  logic          tick = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [CW-1:0] result;
  logic          done, ovf, busy;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  evt_interval_timer #(.NUM_PINS(NP), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pin_sel_i(sel),
    .mode_width_i(mode), .target_lvl_i(tgt), .tick_i(tick), .pins_i(pins),
    .result_o(result), .done_o(done), .ovf_o(ovf), .busy_o(busy));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input int p, input bit m, input bit t);
    @(negedge clk);
    start = 1'b1; sel = 3'(p); mode = m; tgt = t;
    @(negedge clk);
    start = 1'b0;
  endtask

  // edge mode: n ticks then transition to target; last_tick ticks on the ending edge
  task automatic run_edge(input int p, input bit t, input int n, input bit last_tick);
    int other;
    other = (p == NP-1) ? 1 : p + 1;
    pins = {NP{~t}};
    cyc(2);
    do_start(p, 1'b0, t);
    pins[other] = t;  // R6: unselected pin reaches target, must be ignored
    tick = (n > 0);
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = last_tick;
    pins[p] = t;
    @(negedge clk);
    tick = 1'b0;
    check($sformatf("R2/R4/R6 edge p%0d t%0d n%0d res", p, t, n), int'(result), n);
    check("R2 edge done", int'(done), 1);
    check("R2 edge busy", int'(busy), 0);
  endtask

  task automatic run_width(input int p, input bit t, input int n);
    pins = {NP{~t}};
    cyc(2);
    do_start(p, 1'b1, t);
    tick = 1'b1;
    cyc(4);  // R3: pre-arm ticks not counted
    tick = 1'b0;
    check("R3 width armed wait", int'(busy), 1);
    pins[p] = t;
    @(negedge clk);
    tick = (n > 0);
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = 1'b1;  // tick on ending edge excluded
    pins[p] = ~t;
    @(negedge clk);
    tick = 1'b0;
    check($sformatf("R3/R4 width p%0d t%0d n%0d res", p, t, n), int'(result), n);
    check("R3 width done", int'(done), 1);
  endtask

  initial begin : watchdog
    cyc(190000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [CW-1:0] snap;
    cyc(3);
    // R1
    check("R1 reset result", int'(result), 0);
    check("R1 reset done", int'(done), 0);
    check("R1 reset ovf", int'(ovf), 0);
    check("R1 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    cyc(2);

    for (int p = 1; p < NP; p++)
      for (int t = 0; t < 2; t++) begin
        run_edge(p, t[0], 0, 1'b0);
        run_edge(p, t[0], 3 + p, 1'b1);
        run_edge(p, t[0], 17, 1'b0);
        run_width(p, t[0], 0);
        run_width(p, t[0], 2 * p + 5);
      end

    // R8: stable after done
    snap = result;
    tick = 1'b1;
    pins = ~pins;
    cyc(5);
    pins = ~pins;
    cyc(5);
    tick = 1'b0;
    check("R8 result held", int'(result), int'(snap));
    check("R8 done held", int'(done), 1);

    // R5: pin 0 ignored
    pins = '0;
    cyc(2);
    do_start(0, 1'b1, 1'b1);
    tick = 1'b1;
    pins[0] = 1'b1;
    cyc(4);
    tick = 1'b0;
    check("R5 pin0 busy", int'(busy), 0);
    check("R5 pin0 done", int'(done), 0);
    check("R5 pin0 result", int'(result), 0);

    // R10: already at target
    pins = '1;
    cyc(2);
    do_start(2, 1'b0, 1'b1);
    tick = 1'b1;
    cyc(6);
    tick = 1'b0;
    check("R10 no end at level", int'(busy), 1);
    check("R10 count", int'(result), 6);
    pins[2] = 1'b0;
    cyc(1);
    pins[2] = 1'b1;
    cyc(1);
    check("R10 fresh edge ends", int'(done), 1);
    check("R10 final", int'(result), 6);

    // R9: restart mid-count
    pins = '0;
    cyc(2);
    do_start(3, 1'b0, 1'b1);
    tick = 1'b1;
    cyc(9);
    tick = 1'b0;
    do_start(3, 1'b0, 1'b1);
    check("R9 restart cleared", int'(result), 0);
    check("R9 restart busy", int'(busy), 1);
    tick = 1'b1;
    cyc(4);
    tick = 1'b0;
    pins[3] = 1'b1;
    cyc(1);
    check("R9 restart result", int'(result), 4);

    // R7: overflow
    pins = '0;
    cyc(2);
    do_start(4, 1'b0, 1'b1);
    tick = 1'b1;
    cyc(65535);
    check("R7 at max not done", int'(done), 0);
    cyc(1);
    tick = 1'b0;
    check("R7 ovf", int'(ovf), 1);
    check("R7 done", int'(done), 1);
    check("R7 result sat", int'(result), 65535);
    pins[4] = 1'b1;
    tick = 1'b1;
    cyc(3);
    tick = 1'b0;
    check("R8 ovf held", int'(ovf), 1);
    check("R8 sat held", int'(result), 65535);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule